// File: doc/BRIEF.md
# Interrupt Request and Delivery Core

This block watches a set of interrupt input pins and turns their activity into delivery messages for a local interrupt controller. Each pin has a routing entry. The entry supplies a vector, a destination, a destination-addressing mode, a delivery mode, a trigger type (edge or level) and a mask bit. The core keeps one pending bit per pin. A pin that needs service offers the message built from its entry on a valid/ready handshake. When more than one pin is ready at once, the lowest-numbered pin goes first.

Edge pins and level pins suppress repeats in different ways.

- **Edge pin:** an edge that arrives while the pin's previous edge request is still outstanding is folded into that request. The core flags this with a one-cycle coalesced pulse.
- **Level pin:** once a message from a level pin is accepted, the pin is blocked by its remote-IRR bit. An end-of-interrupt strobe clears the bit, and so does a rewrite of the pin's routing entry. A level pin that is still pending is then serviced again.

Choosing among destination processors is left to the block that consumes the message.

Top module: `irq_delivery_core`

## Requirements
- R1: A rising input on an unmasked edge pin (trigger bit 0) makes the core raise `dlv_valid` two clock edges later. The message carries that pin's index, vector, destination, delivery mode and destination-mode bit, with `dlv_level` = 0. Edge pins never set remote IRR.
- R2: While `dlv_valid` is high and `dlv_ready` is low, every message field stays unchanged. After an edge where both are high, `dlv_valid` is low for at least one cycle.
- R3: When several pins want delivery on the same edge, the lowest pin index is offered first. The others follow after it has been accepted.
- R4: A rising edge on an edge pin whose earlier request has not been accepted yet produces a one-cycle pulse on that pin's `coalesced` bit. It produces no extra delivery.
- R5: A pin whose mask bit is 1 is never offered while it is masked. A level pin that asserted while masked stays pending, and it is offered once an entry write clears its mask.
- R6: When a message with `dlv_level` = 1 is accepted, that pin's `remote_irr` bit is 1 from the next cycle on.
- R7: A level pin whose `remote_irr` bit is 1 is not offered. A rising edge on such a pin pulses its `coalesced` bit.
- R8: An `eoi_clr` strobe clears the pin's `remote_irr` bit. A level pin whose input is still asserted is then offered again.
- R9: An `rte_wr` strobe clears the pin's `remote_irr` bit. If the pin is level-triggered and pending, it is serviced again.
- R10: When a pin's input goes low, its pending bit is cleared. A level pin that drops before its end of interrupt is not offered again after the end of interrupt.
- R11: After reset, `dlv_valid`, `remote_irr` and `coalesced` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Interrupt input levels |
| rte_vector | input | NPINS*VEC_W | Per-pin vector, pin i at [i*VEC_W +: VEC_W] |
| rte_dest | input | NPINS*DEST_W | Per-pin destination field |
| rte_dmode | input | NPINS*DMODE_W | Per-pin delivery mode |
| rte_logical | input | NPINS | Per-pin destination-addressing mode bit |
| rte_level | input | NPINS | Per-pin trigger type, 1 = level, 0 = edge |
| rte_mask | input | NPINS | Per-pin mask, 1 = masked |
| rte_wr | input | NPINS | Per-pin strobe: routing entry was written |
| eoi_clr | input | NPINS | Per-pin end-of-interrupt strobe |
| dlv_ready | input | 1 | Message accepted by the consumer |
| dlv_valid | output | 1 | A message is offered |
| dlv_pin | output | $clog2(NPINS) | Index of the pin being delivered |
| dlv_vector | output | VEC_W | Message vector |
| dlv_dest | output | DEST_W | Message destination |
| dlv_dmode | output | DMODE_W | Message delivery mode |
| dlv_logical | output | 1 | Message destination-addressing mode |
| dlv_level | output | 1 | Message trigger type |
| remote_irr | output | NPINS | Per-pin remote IRR state |
| coalesced | output | NPINS | Per-pin one-cycle coalesced-request pulse |

## Verification
The bench builds the core with its defaults: eight pins, eight-bit vector and destination fields, and a three-bit delivery mode. With eight pins, the bench can offer requests from non-adjacent pins on the same edge, and the pin index uses the full three bits up to pin 7. One level pin is walked through its whole life:
- masked assert;
- unmask by entry write;
- accept;
- blocked re-assert;
- end of interrupt;
- rewrite;
- deassert before end of interrupt.

Two edge pins cover coalescing while a message is held back by a low ready.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/irqd_pin_state.sv
module irqd_pin_state
   import irqd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   input  logic is_level,
   input  logic masked,
   input  logic entry_wr,
   input  logic eoi_hit,
   input  logic accept_this,
   output logic want,
   output logic rirr,
   output logic coalesce
);
   trig_e mode;
   logic  irq_q;
   logic  pend;
   logic  edge_req;
   logic  rise;

   assign mode = trig_e'(is_level);
   assign rise = irq & ~irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q    <= 1'b0;
         pend     <= 1'b0;
         edge_req <= 1'b0;
         rirr     <= 1'b0;
         coalesce <= 1'b0;
      end else begin
         irq_q <= irq;
         // pending follows the line: dropped on deassert, set on assertion
         if (!irq)
            pend <= 1'b0;
         else if (rise)
            pend <= 1'b1;
         // an edge request lives until its message is accepted
         edge_req <= (edge_req & ~accept_this) |
                     (rise & (mode == TRIG_EDGE) & ~edge_req);
         // setting on a level accept wins over a clear in the same cycle
         if (accept_this && mode == TRIG_LEVEL)
            rirr <= 1'b1;
         else if (entry_wr || eoi_hit)
            rirr <= 1'b0;
         coalesce <= rise & ((mode == TRIG_LEVEL) ? rirr : edge_req);
      end
   end

   always_comb begin
      if (mode == TRIG_LEVEL)
         want = ~masked & pend & ~rirr;
      else
         want = ~masked & edge_req;
   end
endmodule

// File: rtl/irqd_first_pick.sv
module irqd_first_pick #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     want,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (want[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqd_msg_hold.sv
module irqd_msg_hold #(
   parameter int IDX_W   = 3,
   parameter int VEC_W   = 8,
   parameter int DEST_W  = 8,
   parameter int DMODE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               accept,
   input  logic [IDX_W-1:0]   in_pin,
   input  logic [VEC_W-1:0]   in_vector,
   input  logic [DEST_W-1:0]  in_dest,
   input  logic [DMODE_W-1:0] in_dmode,
   input  logic               in_logical,
   input  logic               in_level,
   output logic               valid,
   output logic [IDX_W-1:0]   pin,
   output logic [VEC_W-1:0]   vector,
   output logic [DEST_W-1:0]  dest,
   output logic [DMODE_W-1:0] dmode,
   output logic               logical,
   output logic               level
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         pin     <= '0;
         vector  <= '0;
         dest    <= '0;
         dmode   <= '0;
         logical <= 1'b0;
         level   <= 1'b0;
      end else if (load) begin
         valid   <= 1'b1;
         pin     <= in_pin;
         vector  <= in_vector;
         dest    <= in_dest;
         dmode   <= in_dmode;
         logical <= in_logical;
         level   <= in_level;
      end else if (accept) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_delivery_core.sv
module irq_delivery_core #(
   parameter int NPINS   = 8,
   parameter int VEC_W   = 8,
   parameter int DEST_W  = 8,
   parameter int DMODE_W = 3,
   localparam int IDX_W  = $clog2(NPINS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPINS-1:0]           irq_in,
   input  logic [NPINS*VEC_W-1:0]     rte_vector,
   input  logic [NPINS*DEST_W-1:0]    rte_dest,
   input  logic [NPINS*DMODE_W-1:0]   rte_dmode,
   input  logic [NPINS-1:0]           rte_logical,
   input  logic [NPINS-1:0]           rte_level,
   input  logic [NPINS-1:0]           rte_mask,
   input  logic [NPINS-1:0]           rte_wr,
   input  logic [NPINS-1:0]           eoi_clr,
   input  logic                       dlv_ready,
   output logic                       dlv_valid,
   output logic [IDX_W-1:0]           dlv_pin,
   output logic [VEC_W-1:0]           dlv_vector,
   output logic [DEST_W-1:0]          dlv_dest,
   output logic [DMODE_W-1:0]         dlv_dmode,
   output logic                       dlv_logical,
   output logic                       dlv_level,
   output logic [NPINS-1:0]           remote_irr,
   output logic [NPINS-1:0]           coalesced
);
   if (NPINS < 2 || NPINS > 64) begin : g_bad_npins
      $error("irq_delivery_core: NPINS must lie in 2..64");
   end
   if (VEC_W < 1 || DEST_W < 1 || DMODE_W < 1) begin : g_bad_width
      $error("irq_delivery_core: field widths must be positive");
   end

   logic [NPINS-1:0] want;
   logic [NPINS-1:0] accept_vec;
   logic             any_want;
   logic [IDX_W-1:0] pick;
   logic             load;
   logic             accept;

   assign accept = dlv_valid & dlv_ready;
   assign load   = any_want & ~dlv_valid;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign accept_vec[p] = accept & (dlv_pin == IDX_W'(p));
      irqd_pin_state u_state (
         .clk         (clk),
         .rst_n       (rst_n),
         .irq         (irq_in[p]),
         .is_level    (rte_level[p]),
         .masked      (rte_mask[p]),
         .entry_wr    (rte_wr[p]),
         .eoi_hit     (eoi_clr[p]),
         .accept_this (accept_vec[p]),
         .want        (want[p]),
         .rirr        (remote_irr[p]),
         .coalesce    (coalesced[p])
      );
   end

   irqd_first_pick #(.N(NPINS), .IDX_W(IDX_W)) u_pick (
      .want (want),
      .any  (any_want),
      .idx  (pick)
   );

   irqd_msg_hold #(
      .IDX_W(IDX_W), .VEC_W(VEC_W), .DEST_W(DEST_W), .DMODE_W(DMODE_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .accept     (accept),
      .in_pin     (pick),
      .in_vector  (rte_vector[pick*VEC_W +: VEC_W]),
      .in_dest    (rte_dest[pick*DEST_W +: DEST_W]),
      .in_dmode   (rte_dmode[pick*DMODE_W +: DMODE_W]),
      .in_logical (rte_logical[pick]),
      .in_level   (rte_level[pick]),
      .valid      (dlv_valid),
      .pin        (dlv_pin),
      .vector     (dlv_vector),
      .dest       (dlv_dest),
      .dmode      (dlv_dmode),
      .logical    (dlv_logical),
      .level      (dlv_level)
   );
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int NPINS  = 8,
   parameter int VEC_W  = 8,
   localparam int IDX_W = $clog2(NPINS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] rte_mask,
   input logic             dlv_ready,
   input logic             dlv_valid,
   input logic [IDX_W-1:0] dlv_pin,
   input logic [VEC_W-1:0] dlv_vector,
   input logic             dlv_level,
   input logic [NPINS-1:0] remote_irr
);
   logic [NPINS-1:0] mask_prev;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_prev <= '1;
      else
         mask_prev <= rte_mask;
   end

   // R2: an offered message is held unchanged until accepted
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_pin));

   // R5: a newly offered message never comes from a pin that was masked at selection
   assert_no_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlv_valid) |-> !mask_prev[dlv_pin]);

   // R6: an accepted level message sets that pin's remote IRR
   assert_rirr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && dlv_ready && dlv_level |=> remote_irr[$past(dlv_pin)]);

   // R7: a level pin is never offered while its remote IRR is set
   assert_level_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlv_valid) && dlv_level |-> !remote_irr[dlv_pin]);
endmodule

bind irq_delivery_core irqd_checker #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rte_mask   (rte_mask),
   .dlv_ready  (dlv_ready),
   .dlv_valid  (dlv_valid),
   .dlv_pin    (dlv_pin),
   .dlv_vector (dlv_vector),
   .dlv_level  (dlv_level),
   .remote_irr (remote_irr)
);

// File: tb/irq_delivery_core_test.sv
module irq_delivery_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 8;
   localparam int VW = 8;
   localparam int DW = 8;
   localparam int MW = 3;
   localparam int IW = $clog2(NP);

   // table entry: pin[22:20] vector[19:12] dest[11:4] dmode[3:1] logical[0]
   localparam logic [22:0] TBL [4] = '{
      {3'd0, 8'h31, 8'h01, 3'd0, 1'b0},
      {3'd7, 8'hA7, 8'h5C, 3'd4, 1'b1},
      {3'd1, 8'h42, 8'hF0, 3'd1, 1'b0},
      {3'd4, 8'hE9, 8'h23, 3'd7, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    irq_in = '0;
   logic [NP*VW-1:0] r_vec = '0;
   logic [NP*DW-1:0] r_dest = '0;
   logic [NP*MW-1:0] r_dmode = '0;
   logic [NP-1:0]    r_logical = '0;
   logic [NP-1:0]    r_level = '0;
   logic [NP-1:0]    r_mask = '1;
   logic [NP-1:0]    r_wr = '0;
   logic [NP-1:0]    eoi = '0;
   logic             ready = 1'b0;
   logic             dlv_valid;
   logic [IW-1:0]    dlv_pin;
   logic [VW-1:0]    dlv_vector;
   logic [DW-1:0]    dlv_dest;
   logic [MW-1:0]    dlv_dmode;
   logic             dlv_logical;
   logic             dlv_level;
   logic [NP-1:0]    remote_irr;
   logic [NP-1:0]    coalesced;
   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_delivery_core #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW), .DMODE_W(MW)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .rte_vector(r_vec), .rte_dest(r_dest), .rte_dmode(r_dmode),
      .rte_logical(r_logical), .rte_level(r_level), .rte_mask(r_mask),
      .rte_wr(r_wr), .eoi_clr(eoi), .dlv_ready(ready),
      .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
      .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode), .dlv_logical(dlv_logical),
      .dlv_level(dlv_level), .remote_irr(remote_irr), .coalesced(coalesced)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_entry(input int pin, input logic [7:0] vec, input logic [7:0] dst,
                            input logic [2:0] dm, input logic lg, input logic lvl,
                            input logic msk);
      r_vec[pin*VW +: VW]   = vec;
      r_dest[pin*DW +: DW]  = dst;
      r_dmode[pin*MW +: MW] = dm;
      r_logical[pin]        = lg;
      r_level[pin]          = lvl;
      r_mask[pin]           = msk;
   endtask

   task automatic accept_one();
      ready = 1'b1;
      step(1);
      ready = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R11: reset state
      chk("R11 valid", 32'(dlv_valid), 0);
      chk("R11 remote_irr", 32'(remote_irr), 0);
      chk("R11 coalesced", 32'(coalesced), 0);

      // R1: edge delivery from the table
      for (int k = 0; k < 4; k++) begin
         int p;
         p = int'(TBL[k][22:20]);
         set_entry(p, TBL[k][19:12], TBL[k][11:4], TBL[k][3:1], TBL[k][0], 1'b0, 1'b0);
         irq_in[p] = 1'b1;
         step(2);
         chk("R1 valid", 32'(dlv_valid), 1);
         chk("R1 pin", 32'(dlv_pin), 32'(TBL[k][22:20]));
         chk("R1 vector", 32'(dlv_vector), 32'(TBL[k][19:12]));
         chk("R1 dest", 32'(dlv_dest), 32'(TBL[k][11:4]));
         chk("R1 dmode", 32'(dlv_dmode), 32'(TBL[k][3:1]));
         chk("R1 logical", 32'(dlv_logical), 32'(TBL[k][0]));
         chk("R1 level", 32'(dlv_level), 0);
         accept_one();
         chk("R2 valid drops after accept", 32'(dlv_valid), 0);
         chk("R1 edge leaves remote_irr", 32'(remote_irr), 0);
         irq_in[p] = 1'b0;
         step(1);
      end

      // R3 priority and R2 hold
      set_entry(2, 8'h22, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0);
      set_entry(5, 8'h55, 8'h05, 3'd0, 1'b0, 1'b0, 1'b0);
      irq_in[2] = 1'b1;
      irq_in[5] = 1'b1;
      step(2);
      chk("R3 lowest first", 32'(dlv_pin), 2);
      step(3);
      chk("R2 held valid", 32'(dlv_valid), 1);
      chk("R2 held pin", 32'(dlv_pin), 2);
      chk("R2 held vector", 32'(dlv_vector), 32'h22);
      accept_one();
      chk("R3 gap after accept", 32'(dlv_valid), 0);
      step(1);
      chk("R3 second valid", 32'(dlv_valid), 1);
      chk("R3 second pin", 32'(dlv_pin), 5);
      accept_one();
      irq_in[2] = 1'b0;
      irq_in[5] = 1'b0;
      step(2);

      // R4 edge coalescing
      set_entry(3, 8'h33, 8'h03, 3'd2, 1'b0, 1'b0, 1'b0);
      irq_in[3] = 1'b1;
      step(2);
      chk("R4 first offer pin", 32'(dlv_pin), 3);
      irq_in[3] = 1'b0;
      step(1);
      irq_in[3] = 1'b1;
      step(1);
      chk("R4 coalesced pulse", 32'(coalesced), 32'h08);
      step(1);
      chk("R4 pulse one cycle", 32'(coalesced), 0);
      accept_one();
      step(3);
      chk("R4 no extra delivery", 32'(dlv_valid), 0);
      irq_in[3] = 1'b0;
      step(1);

      // R5 masked level pin
      set_entry(6, 8'h66, 8'h06, 3'd5, 1'b1, 1'b1, 1'b1);
      irq_in[6] = 1'b1;
      step(4);
      chk("R5 masked no offer", 32'(dlv_valid), 0);
      r_mask[6] = 1'b0;
      r_wr[6] = 1'b1;
      step(1);
      r_wr[6] = 1'b0;
      chk("R5 unmask offers", 32'(dlv_valid), 1);
      chk("R5 unmask pin", 32'(dlv_pin), 6);
      chk("R1 level bit", 32'(dlv_level), 1);
      accept_one();
      chk("R6 remote_irr set", 32'(remote_irr), 32'h40);
      step(3);
      chk("R7 blocked", 32'(dlv_valid), 0);
      irq_in[6] = 1'b0;
      step(1);
      irq_in[6] = 1'b1;
      step(1);
      chk("R7 coalesced level", 32'(coalesced), 32'h40);

      // R8 end of interrupt with line still high
      eoi[6] = 1'b1;
      step(1);
      eoi[6] = 1'b0;
      chk("R8 eoi clears", 32'(remote_irr), 0);
      step(1);
      chk("R8 re-offer", 32'(dlv_valid), 1);
      chk("R8 re-offer pin", 32'(dlv_pin), 6);
      accept_one();

      // R9 rewrite re-service
      r_wr[6] = 1'b1;
      step(1);
      r_wr[6] = 1'b0;
      chk("R9 rewrite clears", 32'(remote_irr), 0);
      step(1);
      chk("R9 re-service", 32'(dlv_valid), 1);
      accept_one();
      chk("R6 set again", 32'(remote_irr), 32'h40);

      // R10 deassert before end of interrupt
      irq_in[6] = 1'b0;
      step(1);
      eoi[6] = 1'b1;
      step(1);
      eoi[6] = 1'b0;
      step(3);
      chk("R10 no offer", 32'(dlv_valid), 0);
      chk("R10 remote cleared", 32'(remote_irr), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule